// File: doc/BRIEF.md
# Trace Filter Register Access Router

This block resolves one system-register access per cycle that is aimed at either of two trace filter control registers. One register belongs to the hypervisor level and the other to the kernel level. From the encoding of the access, the privilege level of the requester and a set of configuration bits, the block picks one of five outcomes:

- the access is undefined;
- it traps to EL2;
- it traps to EL3;
- it is redirected to a slot in memory;
- it reaches a register directly.

For a direct access the block also reports which register is really touched. That register can differ from the one named, because a host-mode alias maps the kernel name onto the hypervisor register.

The block holds the storage for both registers. A direct write commits on the next clock edge. A direct read returns the target register with every reserved bit forced to zero. The block also drives a syndrome class for traps and a memory offset for redirected accesses. Exception entry and the memory system sit outside it.

Resolution is a combinational priority chain selected by the requesting level. The chain has four branches:

- user level: always undefined;
- kernel level: EL2 trap, then EL3 trap, then memory redirect, then direct access;
- hypervisor level: EL3 trap, then direct access with the optional alias;
- monitor level: always direct.

The outcome set is the one-hot enumeration `UNDEF`, `TRAP_EL2`, `TRAP_EL3`, `MEM_REDIR`, `DIRECT`. It takes `NONE` when no request matches. Each request is resolved on its own, with no sequence between accesses, so the only state held from cycle to cycle is the two registers.

Top module: `trf_route_unit`

## Requirements
- R1: Any matched access with `cur_el` = 0 gives the outcome UNDEF, whichever register is named.
- R2: A matched access from `cur_el` = 1 that names the hypervisor register gives TRAP_EL2 when `el2_enabled` and `hcr_nv` are both 1, and UNDEF in every other case.
- R3: A matched access from `cur_el` = 2, naming either register, gives TRAP_EL3 when `el3_present`, `el3_is_64` and `el3_trace_trap` are all 1. Otherwise it is DIRECT.
- R4: For the kernel register named from `cur_el` = 1, the first true condition in the following list wins:
  1. TRAP_EL2 when `el2_enabled`, `el2_is_64` and `el2_trace_trap` are all 1;
  2. TRAP_EL3 under the R3 condition;
  3. MEM_REDIR when `el2_enabled`, `el2_is_64`, `hcr_nv2`, `hcr_nv1` and `hcr_nv` are all 1;
  4. DIRECT to the kernel register.
- R5: When the kernel register is named from `cur_el` = 2 and no EL3 trap applies, the target is the hypervisor register if `hcr_e2h` = 1 and the kernel register if `hcr_e2h` = 0. The hypervisor register named from `cur_el` = 2 always targets itself.
- R6: A matched access from `cur_el` = 3 is DIRECT to the named register, whatever the trap and redirect bits are.
- R7: The encoding fields are decoded as follows:
  - a request matches only when `req_op0` = 2'b11, `req_crn` = 4'b0001, `req_crm` = 4'b0010 and `req_op2` = 3'b001;
  - `req_op1` = 3'b100 names the hypervisor register and `req_op1` = 3'b000 names the kernel register;
  - any other encoding gives `route_onehot` = 0 and writes nothing.
- R8: `route_onehot` has bit 0 for UNDEF, bit 1 for TRAP_EL2, bit 2 for TRAP_EL3, bit 3 for MEM_REDIR and bit 4 for DIRECT. Exactly one bit is set for a valid matched request, and all bits are 0 when `req_valid` = 0.
- R9: `trap_class` is 0x18 for TRAP_EL2 and TRAP_EL3 and 0 otherwise. `nv_mem_offset` is 0x880 for MEM_REDIR and 0 otherwise.
- R10: A write changes a register only when its outcome is DIRECT. The new value is visible to a read in the following cycle. Writes with any other outcome leave both registers unchanged.
- R11: Only some bits of each register can be written, and all other bits always read 0:
  - hypervisor register: bits 6, 5, 3, 1 and 0 (mask 0x6B);
  - kernel register: bits 6, 5, 1 and 0 (mask 0x63).
- R12: After reset both registers read 0.
- R13: `rd_data` carries the target register only for a DIRECT read and is 0 for every other outcome and for writes. `direct_hyp` is 1 only for a DIRECT access whose target is the hypervisor register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears both registers |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1, selects the register |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Privilege level of the requester, 0 to 3 |
| el2_enabled | input | 1 | EL2 is enabled in the current security state |
| el2_is_64 | input | 1 | EL2 runs in 64-bit state |
| el3_present | input | 1 | EL3 is implemented |
| el3_is_64 | input | 1 | EL3 runs in 64-bit state |
| el2_trace_trap | input | 1 | EL2 trap bit for trace filter accesses |
| el3_trace_trap | input | 1 | EL3 trap bit for trace filter accesses |
| hcr_nv | input | 1 | Nested virtualization enable |
| hcr_nv1 | input | 1 | Nested virtualization control 1 |
| hcr_nv2 | input | 1 | Nested virtualization memory redirect enable |
| hcr_e2h | input | 1 | Host mode, aliases the kernel name onto the hypervisor register |
| route_onehot | output | 5 | One-hot outcome (see R8) |
| direct_hyp | output | 1 | Direct access targets the hypervisor register |
| trap_class | output | 6 | Trap syndrome class |
| nv_mem_offset | output | 12 | Memory offset for a redirected access |
| rd_data | output | 64 | Read data for a direct read |

## Verification
The checker watches several properties on every cycle:
- the one-hot shape of the outcome, and silence when no request is present;
- the fixed outcomes at user and monitor level;
- the pairing of syndrome class and memory offset with their outcomes;
- zero read data outside direct reads;
- reserved register bits staying zero;
- both registers holding still unless a direct write occurs.

The precedence within the kernel-level chain cannot be shown by a single-cycle property and needs the bench's scenarios. The same holds for the host-mode alias sending a write to the hypervisor register, and for a trapped or redirected write leaving storage untouched as seen by a later read. The bench steps through these with configuration bits chosen so that adjacent links of the chain compete.

// File: rtl/trf_pkg.sv
package trf_pkg;

    typedef enum logic [4:0] {
        RT_NONE      = 5'b00000,
        RT_UNDEF     = 5'b00001,
        RT_TRAP_EL2  = 5'b00010,
        RT_TRAP_EL3  = 5'b00100,
        RT_MEM_REDIR = 5'b01000,
        RT_DIRECT    = 5'b10000
    } route_e;

    typedef enum logic [1:0] {
        LV_USER   = 2'd0,
        LV_KERNEL = 2'd1,
        LV_HYP    = 2'd2,
        LV_MON    = 2'd3
    } level_e;

    typedef struct packed {
        logic el2_on;
        logic el2_wide;
        logic el3_has;
        logic el3_wide;
        logic tt_el2;
        logic tt_el3;
        logic nv;
        logic nv1;
        logic nv2;
        logic e2h;
    } ctl_t;

    localparam int ROUTE_W = 5;
    localparam int BIT_DIRECT = 4;

endpackage

// File: rtl/trf_enc_decode.sv
module trf_enc_decode #(
    parameter logic [1:0] P_OP0     = 2'b11,
    parameter logic [3:0] P_CRN     = 4'b0001,
    parameter logic [3:0] P_CRM     = 4'b0010,
    parameter logic [2:0] P_OP2     = 3'b001,
    parameter logic [2:0] P_OP1_HYP = 3'b100,
    parameter logic [2:0] P_OP1_KRN = 3'b000
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit,
    output logic       names_hyp
);
    logic shared_ok;
    logic hyp_m;
    logic krn_m;

    always_comb begin
        shared_ok = (op0 == P_OP0) && (crn == P_CRN) && (crm == P_CRM) && (op2 == P_OP2);
        hyp_m     = (op1 == P_OP1_HYP);
        krn_m     = (op1 == P_OP1_KRN);
        hit       = shared_ok && (hyp_m || krn_m);
        names_hyp = hyp_m;
    end
endmodule

// File: rtl/trf_route_resolve.sv
module trf_route_resolve
    import trf_pkg::*;
#(
    parameter int               CLASS_W    = 6,
    parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
    parameter int               OFF_W      = 12,
    parameter logic [OFF_W-1:0] REDIR_OFF  = 12'h880
) (
    input  logic               req_on,
    input  logic               hit,
    input  logic               named_hyp,
    input  level_e             lvl,
    input  ctl_t               ctl,
    output route_e             route,
    output logic               tgt_hyp,
    output logic [CLASS_W-1:0] syn_class,
    output logic [OFF_W-1:0]   mem_off
);
    logic el3_trap;
    logic el2_live;
    logic nv_all;

    // Decision process: one branch of the priority chain per requesting level.
    always_comb begin
        el3_trap = ctl.el3_has && ctl.el3_wide && ctl.tt_el3;
        el2_live = ctl.el2_on && ctl.el2_wide;
        nv_all   = ctl.nv2 && ctl.nv1 && ctl.nv;
        route    = RT_NONE;
        tgt_hyp  = named_hyp;
        if (req_on && hit) begin
            unique case (lvl)
                LV_USER: route = RT_UNDEF;
                LV_KERNEL: begin
                    if (named_hyp) begin
                        route = (ctl.el2_on && ctl.nv) ? RT_TRAP_EL2 : RT_UNDEF;
                    end else if (el2_live && ctl.tt_el2) begin
                        route = RT_TRAP_EL2;
                    end else if (el3_trap) begin
                        route = RT_TRAP_EL3;
                    end else if (el2_live && nv_all) begin
                        route = RT_MEM_REDIR;
                    end else begin
                        route = RT_DIRECT;
                    end
                end
                LV_HYP: begin
                    if (el3_trap) begin
                        route = RT_TRAP_EL3;
                    end else begin
                        route = RT_DIRECT;
                        if (!named_hyp && ctl.e2h) begin
                            tgt_hyp = 1'b1;
                        end
                    end
                end
                LV_MON: route = RT_DIRECT;
                default: route = RT_NONE;
            endcase
        end
    end

    // Output process: side-band values derived from the chosen outcome.
    always_comb begin
        syn_class = '0;
        mem_off   = '0;
        unique case (route)
            RT_TRAP_EL2, RT_TRAP_EL3: syn_class = TRAP_CLASS;
            RT_MEM_REDIR:             mem_off   = REDIR_OFF;
            default: begin
                syn_class = '0;
                mem_off   = '0;
            end
        endcase
    end
endmodule

// File: rtl/trf_reg_bank.sv
module trf_reg_bank #(
    parameter int                DATA_W   = 64,
    parameter logic [DATA_W-1:0] HYP_MASK = 64'h6B,
    parameter logic [DATA_W-1:0] KRN_MASK = 64'h63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel_hyp,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] hyp_state,
    output logic [DATA_W-1:0] krn_state
);
    localparam int N_REGS = 2;

    logic [DATA_W-1:0] slot_q [N_REGS];

    // Slot 0 is the kernel register, slot 1 the hypervisor register.
    for (genvar g = 0; g < N_REGS; g++) begin : g_slot
        localparam logic [DATA_W-1:0] MASK = (g == 1) ? HYP_MASK : KRN_MASK;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (sel_hyp == (g == 1))) begin
                slot_q[g] <= wdata & MASK;
            end
        end
    end

    always_comb begin
        rdata     = rd_en ? slot_q[sel_hyp] : '0;
        hyp_state = slot_q[1];
        krn_state = slot_q[0];
    end
endmodule

// File: rtl/trf_route_unit.sv
module trf_route_unit
    import trf_pkg::*;
#(
    parameter int                DATA_W     = 64,
    parameter int                CLASS_W    = 6,
    parameter int                OFF_W      = 12,
    parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
    parameter logic [OFF_W-1:0]  REDIR_OFF  = 12'h880,
    parameter logic [DATA_W-1:0] HYP_MASK   = 64'h6B,
    parameter logic [DATA_W-1:0] KRN_MASK   = 64'h63
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_op0,
    input  logic [2:0]         req_op1,
    input  logic [3:0]         req_crn,
    input  logic [3:0]         req_crm,
    input  logic [2:0]         req_op2,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [1:0]         cur_el,
    input  logic               el2_enabled,
    input  logic               el2_is_64,
    input  logic               el3_present,
    input  logic               el3_is_64,
    input  logic               el2_trace_trap,
    input  logic               el3_trace_trap,
    input  logic               hcr_nv,
    input  logic               hcr_nv1,
    input  logic               hcr_nv2,
    input  logic               hcr_e2h,
    output logic [4:0]         route_onehot,
    output logic               direct_hyp,
    output logic [CLASS_W-1:0] trap_class,
    output logic [OFF_W-1:0]   nv_mem_offset,
    output logic [DATA_W-1:0]  rd_data
);
    logic              enc_hit;
    logic              enc_hyp;
    logic              tgt_hyp;
    logic              is_direct;
    route_e            route;
    ctl_t              ctl;
    logic [DATA_W-1:0] hyp_st;
    logic [DATA_W-1:0] krn_st;

    always_comb begin
        ctl = '{el2_on:   el2_enabled,
                el2_wide: el2_is_64,
                el3_has:  el3_present,
                el3_wide: el3_is_64,
                tt_el2:   el2_trace_trap,
                tt_el3:   el3_trace_trap,
                nv:       hcr_nv,
                nv1:      hcr_nv1,
                nv2:      hcr_nv2,
                e2h:      hcr_e2h};
    end

    trf_enc_decode u_dec (
        .op0       (req_op0),
        .op1       (req_op1),
        .crn       (req_crn),
        .crm       (req_crm),
        .op2       (req_op2),
        .hit       (enc_hit),
        .names_hyp (enc_hyp)
    );

    trf_route_resolve #(
        .CLASS_W    (CLASS_W),
        .TRAP_CLASS (TRAP_CLASS),
        .OFF_W      (OFF_W),
        .REDIR_OFF  (REDIR_OFF)
    ) u_res (
        .req_on    (req_valid),
        .hit       (enc_hit),
        .named_hyp (enc_hyp),
        .lvl       (level_e'(cur_el)),
        .ctl       (ctl),
        .route     (route),
        .tgt_hyp   (tgt_hyp),
        .syn_class (trap_class),
        .mem_off   (nv_mem_offset)
    );

    always_comb begin
        is_direct    = (route == RT_DIRECT);
        route_onehot = route;
        direct_hyp   = is_direct && tgt_hyp;
    end

    trf_reg_bank #(
        .DATA_W   (DATA_W),
        .HYP_MASK (HYP_MASK),
        .KRN_MASK (KRN_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (is_direct && req_write),
        .sel_hyp   (tgt_hyp),
        .wdata     (req_wdata),
        .rd_en     (is_direct && !req_write),
        .rdata     (rd_data),
        .hyp_state (hyp_st),
        .krn_state (krn_st)
    );
endmodule

// File: rtl/trf_route_chk.sv
module trf_route_chk #(
    parameter int                DATA_W   = 64,
    parameter int                CLASS_W  = 6,
    parameter int                OFF_W    = 12,
    parameter logic [DATA_W-1:0] HYP_MASK = 64'h6B,
    parameter logic [DATA_W-1:0] KRN_MASK = 64'h63
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic               enc_hit,
    input logic [1:0]         cur_el,
    input logic [4:0]         route_onehot,
    input logic               direct_hyp,
    input logic [CLASS_W-1:0] trap_class,
    input logic [OFF_W-1:0]   nv_mem_offset,
    input logic [DATA_W-1:0]  rd_data,
    input logic [DATA_W-1:0]  hyp_st,
    input logic [DATA_W-1:0]  krn_st
);
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit) |-> ($countones(route_onehot) == 1));

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (route_onehot == 5'b0));

    a_r1_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && cur_el == 2'd0) |-> (route_onehot == 5'b00001));

    a_r6_mon_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && cur_el == 2'd3) |-> (route_onehot == 5'b10000));

    a_r9_class: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_class != '0) == (route_onehot[1] || route_onehot[2]));

    a_r9_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_mem_offset != '0) == route_onehot[3]);

    a_r13_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_onehot[4] && !req_write) |-> (rd_data == '0));

    a_r13_direct_hyp: assert property (@(posedge clk) disable iff (!rst_n)
        direct_hyp |-> route_onehot[4]);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && route_onehot[4]) |=> ($stable(hyp_st) && $stable(krn_st)));

    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ((hyp_st & ~HYP_MASK) == '0) && ((krn_st & ~KRN_MASK) == '0));
endmodule

bind trf_route_unit trf_route_chk #(
    .DATA_W   (DATA_W),
    .CLASS_W  (CLASS_W),
    .OFF_W    (OFF_W),
    .HYP_MASK (HYP_MASK),
    .KRN_MASK (KRN_MASK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .enc_hit       (enc_hit),
    .cur_el        (cur_el),
    .route_onehot  (route_onehot),
    .direct_hyp    (direct_hyp),
    .trap_class    (trap_class),
    .nv_mem_offset (nv_mem_offset),
    .rd_data       (rd_data),
    .hyp_st        (hyp_st),
    .krn_st        (krn_st)
);

// File: tb/sim_trf_route_unit.sv
module sim_trf_route_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b000;
    logic [3:0]  req_crn = 4'b0001, req_crm = 4'b0010;
    logic [2:0]  req_op2 = 3'b001;
    logic [63:0] req_wdata = '0;
    logic [1:0]  cur_el = 2'd0;
    logic el2_enabled = 0, el2_is_64 = 0, el3_present = 0, el3_is_64 = 0;
    logic el2_trace_trap = 0, el3_trace_trap = 0;
    logic hcr_nv = 0, hcr_nv1 = 0, hcr_nv2 = 0, hcr_e2h = 0;
    logic [4:0]  route_onehot;
    logic        direct_hyp;
    logic [5:0]  trap_class;
    logic [11:0] nv_mem_offset;
    logic [63:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] m_hyp = '0;
    logic [63:0] m_krn = '0;

    always #5 clk = ~clk;

    trf_route_unit u0 (.*);

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural expectation: outcome code 0..4 = undef, trap2, trap3, mem, direct; -1 = none.
    function automatic int expect_route(input int el, input bit hyp_name, output bit tgt);
        bit t3 = el3_present && el3_is_64 && el3_trace_trap;
        bit e2 = el2_enabled && el2_is_64;
        tgt = hyp_name;
        if (el == 0) return 0;
        if (el == 3) return 4;
        if (el == 2) begin
            if (t3) return 2;
            if (!hyp_name && hcr_e2h) tgt = 1;
            return 4;
        end
        if (hyp_name) return (el2_enabled && hcr_nv) ? 1 : 0;
        if (e2 && el2_trace_trap) return 1;
        if (t3) return 2;
        if (e2 && hcr_nv && hcr_nv1 && hcr_nv2) return 3;
        return 4;
    endfunction

    task automatic access_raw(input string tag, input int el, input logic [1:0] o0, input logic [2:0] o1,
                              input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                              input bit wr, input logic [63:0] data);
        bit matched, tgt;
        int rc;
        logic [4:0]  e_oh;
        logic [63:0] e_rd;
        @(negedge clk);
        req_valid = 1; req_write = wr; cur_el = el[1:0];
        req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2; req_wdata = data;
        #2;
        matched = (o0 == 2'b11) && (cn == 4'b0001) && (cm == 4'b0010) && (o2 == 3'b001) &&
                  (o1 == 3'b100 || o1 == 3'b000);
        rc = matched ? expect_route(el, o1 == 3'b100, tgt) : -1;
        if (!matched) tgt = 0;
        e_oh = (rc < 0) ? 5'b0 : 5'(1 << rc);
        e_rd = (rc == 4 && !wr) ? (tgt ? m_hyp : m_krn) : 64'h0;
        chk(tag, "route", 64'(route_onehot), 64'(e_oh));
        chk(tag, "class", 64'(trap_class), (rc == 1 || rc == 2) ? 64'h18 : 64'h0);
        chk(tag, "offset", 64'(nv_mem_offset), (rc == 3) ? 64'h880 : 64'h0);
        chk(tag, "direct_hyp", 64'(direct_hyp), 64'(rc == 4 && tgt));
        chk(tag, "rd_data", rd_data, e_rd);
        if (rc == 4 && wr) begin
            if (tgt) m_hyp = data & 64'h6B;
            else     m_krn = data & 64'h63;
        end
        @(posedge clk); #1;
        req_valid = 0; req_write = 0;
    endtask

    task automatic access(input string tag, input int el, input bit hyp, input bit wr, input logic [63:0] data);
        access_raw(tag, el, 2'b11, hyp ? 3'b100 : 3'b000, 4'b0001, 4'b0010, 3'b001, wr, data);
    endtask

    task automatic idle_chk(input string tag);
        @(negedge clk);
        req_valid = 0; req_op1 = 3'b100; cur_el = 2'd3;
        #2;
        chk(tag, "idle route", 64'(route_onehot), 64'h0);
        chk(tag, "idle rd_data", rd_data, 64'h0);
        @(posedge clk); #1;
    endtask

    task automatic clear_cfg();
        el2_enabled = 0; el2_is_64 = 0; el3_present = 0; el3_is_64 = 0;
        el2_trace_trap = 0; el3_trace_trap = 0;
        hcr_nv = 0; hcr_nv1 = 0; hcr_nv2 = 0; hcr_e2h = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R12 reset value, via monitor-level reads (R6)
        access("R12", 3, 1, 0, 0);
        access("R12", 3, 0, 0, 0);
        idle_chk("R8");

        // R1 user level, then confirm nothing written (R10)
        el3_present = 1; el3_is_64 = 1;
        access("R1", 0, 1, 0, 0);
        access("R1", 0, 0, 1, 64'hFF);
        access("R10", 3, 0, 0, 0);

        // R2 hypervisor register named from kernel level
        clear_cfg();
        el2_enabled = 1; hcr_nv = 1;
        access("R2", 1, 1, 1, 64'hFF);
        hcr_nv = 0;
        access("R2", 1, 1, 0, 0);
        el2_enabled = 0; hcr_nv = 1;
        access("R2", 1, 1, 0, 0);

        // R3 hypervisor level with EL3 trap
        clear_cfg();
        el3_present = 1; el3_is_64 = 1; el3_trace_trap = 1;
        access("R3", 2, 1, 1, 64'hFF);
        access("R3", 2, 0, 0, 0);
        el3_is_64 = 0;
        access("R3", 2, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        access("R11", 3, 1, 0, 0);

        // R4 kernel-level chain precedence
        clear_cfg();
        el2_enabled = 1; el2_is_64 = 1; el2_trace_trap = 1;
        el3_present = 1; el3_is_64 = 1; el3_trace_trap = 1;
        hcr_nv = 1; hcr_nv1 = 1; hcr_nv2 = 1;
        access("R4", 1, 0, 1, 64'h63);
        el2_is_64 = 0;
        access("R4", 1, 0, 1, 64'h63);
        el2_is_64 = 1; el2_trace_trap = 0; el3_trace_trap = 0;
        access("R4", 1, 0, 1, 64'h63);
        access("R10", 3, 0, 0, 0);
        hcr_nv1 = 0;
        access("R4", 1, 0, 1, 64'hFFFF_0000_0000_00FF);
        access("R11", 3, 0, 0, 0);

        // R5 host alias from hypervisor level
        clear_cfg();
        hcr_e2h = 1;
        access("R5", 2, 0, 1, 64'h0000_0000_0000_0022);
        access("R5", 3, 1, 0, 0);
        access("R5", 3, 0, 0, 0);
        hcr_e2h = 0;
        access("R5", 2, 0, 1, 64'h0000_0000_0000_0041);
        access("R5", 2, 0, 0, 0);
        access("R5", 2, 1, 0, 0);

        // R6 monitor level ignores every trap bit
        el2_enabled = 1; el2_is_64 = 1; el2_trace_trap = 1;
        el3_present = 1; el3_is_64 = 1; el3_trace_trap = 1;
        hcr_nv = 1; hcr_nv1 = 1; hcr_nv2 = 1; hcr_e2h = 1;
        access("R6", 3, 0, 1, 64'h0);
        access("R6", 3, 1, 1, 64'h08);
        access("R6", 3, 1, 0, 0);
        access("R6", 3, 0, 0, 0);

        // R7 encoding mismatches write nothing
        access_raw("R7", 3, 2'b11, 3'b001, 4'b0001, 4'b0010, 3'b001, 1, 64'h0);
        access_raw("R7", 3, 2'b11, 3'b100, 4'b0001, 4'b0011, 3'b001, 1, 64'h0);
        access_raw("R7", 3, 2'b10, 3'b100, 4'b0001, 4'b0010, 3'b001, 1, 64'h0);
        access("R7", 3, 1, 0, 0);

        // R9 and R13 covered across all accesses above; extra mem read
        clear_cfg();
        el2_enabled = 1; el2_is_64 = 1; hcr_nv = 1; hcr_nv1 = 1; hcr_nv2 = 1;
        access("R9", 1, 0, 0, 0);
        access("R13", 1, 1, 0, 0);
        idle_chk("R8");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule